// File: doc/BRIEF.md
# Committed-Frame Transmit Buffer

This block sits between a 32-bit APB register port and a byte-wide transmit stream that feeds an Ethernet MAC. Software loads a frame in three steps. It sets the frame's byte count, pushes the payload as whole 32-bit words, and then issues a commit. Until that commit, the stored words are held back from the MAC side. The stream therefore sees only complete frames, which it can drain at one byte per clock with no risk of running dry partway through a frame.

At commit time the byte count and the end position of the frame go into a small queue of frame descriptors. The stream side walks the head descriptor one byte at a time, least significant byte first, and raises the last-byte marker on the final counted byte. Any pad bytes in the final word are dropped, and so is any surplus word written beyond the count. When the count is zero, when it needs more words than were written, when words were lost to a full buffer, or when the descriptor queue is full, the commit is refused and the pending words are discarded. A status register gives the free word count, a sticky overflow flag and the outcome of the last commit.

Top module: `tx_commit_fifo`

## Requirements
- R1: The register offsets, decoded from paddr[3:2], are: 0x0 length (bits LEN_W-1:0 hold the frame byte count), 0x4 data word push, 0x8 commit (any written value), and 0xC status. Reading status returns free words in [15:0], the rejected-commit flag in bit 30 and the overflow flag in bit 31. Writing status with bit 31 set clears the overflow flag. pready is always 1.
- R2: tvalid stays low until a commit is accepted. It goes high in the cycle after the commit's APB access phase.
- R3: Within each stored word the bytes leave in little-endian order: bits 7:0 first, then 15:8, 23:16 and 31:24.
- R4: A frame with byte count L sends exactly L bytes, with tlast only on byte L-1. The unused tail bytes of the last word are never sent, and neither are surplus whole words written beyond ceil(L/4).
- R5: While tvalid is high and tready is low, tdata and tlast hold their values and tvalid stays high.
- R6: With tready held high, committed frames stream back to back with tvalid high on every cycle, including across frame boundaries.
- R7: Free words equal WORDS minus the words that have been written and whose frame has not yet sent its last byte, or whose frame is still pending a commit. A frame's space returns on the cycle after its last byte is accepted.
- R8: A data write made while free words are 0 is not stored and sets the overflow flag. The flag stays set until it is cleared through the status register.
- R9: A commit that follows a lost data write is refused, the pending words are discarded, and free words return to their value before the frame.
- R10: A commit with a byte count of 0, or one needing more than the number of words written, is refused: the pending words are discarded and status bit 30 is set. An accepted commit clears bit 30.
- R11: A commit made while DESCS committed frames are still waiting is refused, and the frames already queued are sent unchanged.
- R12: After reset tvalid is low, free words equal WORDS, and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 4 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| tdata | output | 8 | Stream byte |
| tvalid | output | 1 | Stream byte valid |
| tready | input | 1 | Stream sink ready |
| tlast | output | 1 | Final byte of a frame |

## Verification
The bench builds the block with an 8-word buffer and room for 2 queued descriptors. With these values a single 9-word push reaches the overflow path, and two unsent frames fill the descriptor queue, so both refusal paths are exercised with short directed sequences. The small buffer also makes the pointers wrap several times during the run. This puts stale data near the read pointer, so a wrong byte lane or a wrong end-of-frame skip would show up in the sent bytes.

// File: rtl/tx_commit_fifo_pkg.sv
package tx_commit_fifo_pkg;

  localparam logic [1:0] REG_LEN    = 2'd0;
  localparam logic [1:0] REG_DATA   = 2'd1;
  localparam logic [1:0] REG_COMMIT = 2'd2;
  localparam logic [1:0] REG_STATUS = 2'd3;

  // Control-to-datapath strobes
  typedef struct packed {
    logic       memWe;
    logic [1:0] laneSel;
  } dpStrobe_t;

endpackage

// File: rtl/tx_commit_fifo_dp.sv
module tx_commit_fifo_dp
  import tx_commit_fifo_pkg::*;
#(
  parameter int WORDS = 512,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  dpStrobe_t     strobe,
  input  logic [AW-1:0] memWa,
  input  logic [AW-1:0] memRa,
  input  logic [31:0]   wrWord,
  output logic [7:0]    tdata
);

  logic [31:0] mem [WORDS];
  logic [31:0] rdWord;
  logic [7:0]  lanes [4];

  always_ff @(posedge clk) begin
    if (strobe.memWe) mem[memWa] <= wrWord;
  end

  assign rdWord = mem[memRa];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lanes[g] = rdWord[8*g +: 8];
  end

  assign tdata = lanes[strobe.laneSel];

endmodule

// File: rtl/tx_commit_fifo_ctl.sv
module tx_commit_fifo_ctl
  import tx_commit_fifo_pkg::*;
#(
  parameter int WORDS = 512,
  parameter int DESCS = 8,
  parameter int LEN_W = 16,
  localparam int AW  = $clog2(WORDS),
  localparam int PW  = AW + 1,
  localparam int DAW = $clog2(DESCS),
  localparam int DPW = DAW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [3:0]    paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  input  logic          tready,
  output logic          tvalid,
  output logic          tlast,
  output dpStrobe_t     strobe,
  output logic [AW-1:0] memWa,
  output logic [AW-1:0] memRa,
  output logic [PW-1:0] freeWords,
  output logic          ovfFlag
);

  // Write side pointers: wrPtr is speculative, commitPtr marks released data
  logic [PW-1:0]    wrPtr, commitPtr, rdPtr;
  logic [LEN_W-1:0] lenReg;
  logic             frameBad, rejFlag;

  // Descriptor queue
  logic [LEN_W-1:0] dLen [DESCS];
  logic [PW-1:0]    dEnd [DESCS];
  logic [DPW-1:0]   descWr, descRd;

  // Read sequencer
  logic [LEN_W-1:0] byteIdx;

  logic             apbWr, dataWr, commitWr, clearOvf, full, descFull;
  logic             descAvail, commitOk, popByte;
  logic [1:0]       regSel;
  logic [PW-1:0]    usedWords, pendWords;
  logic [LEN_W:0]   needWords, pendExt;
  logic [LEN_W-1:0] headLen;
  logic [PW-1:0]    headEnd;
  logic             unusedBits;

  assign regSel    = paddr[3:2];
  assign apbWr     = psel && penable && pwrite;
  assign dataWr    = apbWr && (regSel == REG_DATA);
  assign commitWr  = apbWr && (regSel == REG_COMMIT);
  assign clearOvf  = apbWr && (regSel == REG_STATUS) && pwdata[31];
  assign unusedBits = ^{paddr[1:0], pwdata[30:LEN_W]};

  assign usedWords = wrPtr - rdPtr;
  assign freeWords = PW'(WORDS) - usedWords;
  assign full      = (usedWords == PW'(WORDS));
  assign pendWords = wrPtr - commitPtr;
  assign needWords = ({1'b0, lenReg} + (LEN_W+1)'(3)) >> 2;
  assign pendExt   = (LEN_W+1)'(pendWords);
  assign descFull  = ((descWr - descRd) == DPW'(DESCS));
  assign descAvail = (descWr != descRd);
  assign commitOk  = !frameBad && (lenReg != '0) && (needWords <= pendExt) && !descFull;

  assign headLen   = dLen[descRd[DAW-1:0]];
  assign headEnd   = dEnd[descRd[DAW-1:0]];
  assign tvalid    = descAvail;
  assign tlast     = descAvail && (byteIdx == headLen - 1'b1);
  assign popByte   = tvalid && tready;

  assign memWa          = wrPtr[AW-1:0];
  assign memRa          = rdPtr[AW-1:0] + AW'(byteIdx >> 2);
  assign strobe.memWe   = dataWr && !full;
  assign strobe.laneSel = byteIdx[1:0];
  assign ovfFlag        = ovfStore;

  logic ovfStore;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite && regSel == REG_STATUS) begin
      prdata[15:0] = 16'(freeWords);
      prdata[30]   = rejFlag;
      prdata[31]   = ovfStore;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      commitPtr <= '0;
      lenReg    <= '0;
      frameBad  <= 1'b0;
      ovfStore  <= 1'b0;
      rejFlag   <= 1'b0;
      descWr    <= '0;
    end else begin
      if (apbWr && regSel == REG_LEN) lenReg <= pwdata[LEN_W-1:0];
      if (dataWr) begin
        if (full) begin
          ovfStore <= 1'b1;
          frameBad <= 1'b1;
        end else begin
          wrPtr <= wrPtr + 1'b1;
        end
      end
      if (clearOvf) ovfStore <= 1'b0;
      if (commitWr) begin
        frameBad <= 1'b0;
        if (commitOk) begin
          commitPtr <= wrPtr;
          descWr    <= descWr + 1'b1;
          rejFlag   <= 1'b0;
        end else begin
          wrPtr   <= commitPtr;
          rejFlag <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commitWr && commitOk) begin
      dLen[descWr[DAW-1:0]] <= lenReg;
      dEnd[descWr[DAW-1:0]] <= wrPtr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr   <= '0;
      descRd  <= '0;
      byteIdx <= '0;
    end else if (popByte) begin
      if (tlast) begin
        byteIdx <= '0;
        rdPtr   <= headEnd;
        descRd  <= descRd + 1'b1;
      end else begin
        byteIdx <= byteIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tx_commit_fifo.sv
module tx_commit_fifo
  import tx_commit_fifo_pkg::*;
#(
  parameter int WORDS = 512,
  parameter int DESCS = 8,
  parameter int LEN_W = 16,
  localparam int AW = $clog2(WORDS),
  localparam int PW = AW + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [3:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic [7:0]  tdata,
  output logic        tvalid,
  input  logic        tready,
  output logic        tlast
);

  dpStrobe_t     strobe;
  logic [AW-1:0] memWa, memRa;
  logic [PW-1:0] freeWords;
  logic          ovfFlag;

  assign pready = 1'b1;

  tx_commit_fifo_ctl #(.WORDS(WORDS), .DESCS(DESCS), .LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .tready(tready),
    .tvalid(tvalid), .tlast(tlast), .strobe(strobe), .memWa(memWa),
    .memRa(memRa), .freeWords(freeWords), .ovfFlag(ovfFlag)
  );

  tx_commit_fifo_dp #(.WORDS(WORDS)) u_dp (
    .clk(clk), .strobe(strobe), .memWa(memWa), .memRa(memRa),
    .wrWord(pwdata), .tdata(tdata)
  );

endmodule

// File: rtl/tx_commit_fifo_chk.sv
module tx_commit_fifo_chk #(
  parameter int WORDS = 512,
  parameter int FW = 10
) (
  input logic          clk,
  input logic          rstN,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [3:0]    paddr,
  input logic [31:0]   pwdata,
  input logic [7:0]    tdata,
  input logic          tvalid,
  input logic          tready,
  input logic          tlast,
  input logic [FW-1:0] freeWords,
  input logic          ovfFlag
);

  logic wrAcc, commitAcc, dataAcc, clrAcc;
  assign wrAcc     = psel && penable && pwrite;
  assign commitAcc = wrAcc && paddr[3:2] == 2'd2;
  assign dataAcc   = wrAcc && paddr[3:2] == 2'd1;
  assign clrAcc    = wrAcc && paddr[3:2] == 2'd3 && pwdata[31];

  p_commit_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tvalid) |-> $past(commitAcc));

  p_last_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    tlast |-> tvalid);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tlast)));

  p_free_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    freeWords <= FW'(WORDS));

  p_free_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (freeWords < $past(freeWords)) |-> $past(dataAcc));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrAcc) |=> ovfFlag);

endmodule

bind tx_commit_fifo tx_commit_fifo_chk #(.WORDS(WORDS), .FW(PW)) u_chk (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .tdata(tdata), .tvalid(tvalid),
  .tready(tready), .tlast(tlast), .freeWords(freeWords), .ovfFlag(ovfFlag)
);

// File: tb/tx_commit_fifo_test.sv
module tx_commit_fifo_test;

  localparam int WORDS = 8;
  localparam int DESCS = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [7:0]  tdata;
  logic        tvalid;
  logic        tready = 1'b0;
  logic        tlast;

  int checks = 0;
  int fails  = 0;

  logic [7:0] expB [0:63];
  logic       expL [0:63];

  always #2 clk = ~clk;

  tx_commit_fifo #(.WORDS(WORDS), .DESCS(DESCS)) uut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .tdata(tdata), .tvalid(tvalid), .tready(tready), .tlast(tlast)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic readStatus(output int free, output bit rej, output bit ovf);
    logic [31:0] s;
    apbRead(4'hC, s);
    free = int'(s[15:0]);
    rej  = s[30];
    ovf  = s[31];
  endtask

  // Loads a frame: byte k of frame is base+k, words beyond len carry pattern too
  task automatic loadFrame(input int len, input int nWords, input int base,
                           input int off, input bit doCommit);
    apbWrite(4'h0, 32'(len));
    for (int w = 0; w < nWords; w++) begin
      logic [31:0] wd;
      for (int b = 0; b < 4; b++) wd[8*b +: 8] = 8'(base + 4*w + b);
      apbWrite(4'h4, wd);
    end
    for (int k = 0; k < len; k++) begin
      expB[off+k] = 8'(base + k);
      expL[off+k] = (k == len - 1);
    end
    if (doCommit) apbWrite(4'h8, 32'h1);
  endtask

  task automatic recv(input int n, input bit stall, input string req);
    int got = 0;
    int cyc = 0;
    int gaps = 0;
    while (got < n && cyc < 2000) begin
      @(negedge clk);
      tready = stall ? (cyc % 3 != 2) : 1'b1;
      if (tvalid && tready) begin
        chk(tdata == expB[got], req, "byte", tdata, expB[got]);
        chk(tlast == expL[got], "R4", "tlast", tlast, expL[got]);
        got++;
      end else if (!stall && got > 0) begin
        gaps++;
      end
      cyc++;
    end
    @(posedge clk);
    #1 tready = 1'b0;
    chk(got == n, req, "byte count", got, n);
    if (!stall) chk(gaps == 0, "R6", "idle cycles", gaps, 0);
  endtask

  task automatic t_reset;
    int f; bit r, o;
    #1;
    chk(tvalid == 1'b0, "R12", "tvalid", tvalid, 0);
    readStatus(f, r, o);
    chk(f == WORDS, "R12", "free", f, WORDS);
    chk(r == 1'b0 && o == 1'b0, "R12", "flags", {r, o}, 0);
    chk(pready == 1'b1, "R1", "pready", pready, 1);
  endtask

  task automatic t_basic;
    loadFrame(6, 2, 8'h11, 0, 1'b0);
    #1 chk(tvalid == 1'b0, "R2", "tvalid before commit", tvalid, 0);
    apbWrite(4'h8, 32'h1);
    #1 chk(tvalid == 1'b1, "R2", "tvalid after commit", tvalid, 1);
    recv(6, 1'b0, "R3");
  endtask

  task automatic t_stall;
    loadFrame(8, 2, 8'h40, 0, 1'b1);
    recv(8, 1'b1, "R5");
    loadFrame(1, 1, 8'h90, 0, 1'b1);
    recv(1, 1'b0, "R4");
  endtask

  task automatic t_tail;
    int f; bit r, o;
    loadFrame(5, 2, 8'hA0, 0, 1'b1);
    recv(5, 1'b0, "R4");
    #1 chk(tvalid == 1'b0, "R4", "no tail bytes", tvalid, 0);
    readStatus(f, r, o);
    chk(f == WORDS, "R7", "free after tail frame", f, WORDS);
  endtask

  task automatic t_reject;
    int f; bit r, o;
    loadFrame(0, 1, 8'h10, 0, 1'b1);
    readStatus(f, r, o);
    chk(r == 1'b1, "R10", "reject len 0", r, 1);
    chk(f == WORDS, "R10", "free after reject", f, WORDS);
    chk(tvalid == 1'b0, "R10", "tvalid", tvalid, 0);
    loadFrame(9, 2, 8'h20, 0, 1'b1);
    readStatus(f, r, o);
    chk(r == 1'b1, "R10", "reject short data", r, 1);
    chk(f == WORDS, "R10", "free after short", f, WORDS);
    chk(tvalid == 1'b0, "R10", "tvalid short", tvalid, 0);
    loadFrame(4, 1, 8'h30, 0, 1'b1);
    readStatus(f, r, o);
    chk(r == 1'b0, "R10", "accept clears flag", r, 0);
    recv(4, 1'b0, "R10");
  endtask

  task automatic t_overflow;
    int f; bit r, o;
    loadFrame(36, 9, 8'h50, 0, 1'b0);
    readStatus(f, r, o);
    chk(o == 1'b1, "R8", "overflow flag", o, 1);
    chk(f == 0, "R8", "free when full", f, 0);
    apbWrite(4'h8, 32'h1);
    readStatus(f, r, o);
    chk(r == 1'b1, "R9", "commit refused", r, 1);
    chk(f == WORDS, "R9", "free restored", f, WORDS);
    chk(o == 1'b1, "R8", "flag sticky", o, 1);
    #1 chk(tvalid == 1'b0, "R9", "tvalid", tvalid, 0);
    apbWrite(4'hC, 32'h8000_0000);
    readStatus(f, r, o);
    chk(o == 1'b0, "R8", "flag cleared", o, 0);
  endtask

  task automatic t_backToBack;
    loadFrame(7, 2, 8'h60, 0, 1'b1);
    loadFrame(5, 2, 8'hC0, 7, 1'b1);
    recv(12, 1'b0, "R6");
  endtask

  task automatic t_surplus;
    int f; bit r, o;
    loadFrame(3, 3, 8'h70, 0, 1'b1);
    readStatus(f, r, o);
    chk(f == WORDS - 3, "R7", "free with queued frame", f, WORDS - 3);
    recv(3, 1'b0, "R4");
    readStatus(f, r, o);
    chk(f == WORDS, "R7", "free after surplus", f, WORDS);
    loadFrame(4, 1, 8'hE0, 0, 1'b1);
    recv(4, 1'b0, "R4");
  endtask

  task automatic t_descFull;
    int f; bit r, o;
    loadFrame(4, 1, 8'h01, 0, 1'b1);
    loadFrame(3, 1, 8'h81, 4, 1'b1);
    loadFrame(2, 1, 8'hF1, 0, 1'b1);
    readStatus(f, r, o);
    chk(r == 1'b1, "R11", "third commit refused", r, 1);
    chk(f == WORDS - 2, "R11", "free", f, WORDS - 2);
    for (int k = 0; k < 4; k++) begin
      expB[k] = 8'(8'h01 + k);
      expL[k] = (k == 3);
    end
    recv(7, 1'b0, "R11");
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_stall();
    t_tail();
    t_reject();
    t_overflow();
    t_backToBack();
    t_surplus();
    t_descFull();
    t_backToBack();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule